// File: doc/BRIEF.md
# Serial Memory Controller Event Status and Interrupt Unit

This unit gathers single-cycle event pulses from a serial memory transfer engine into sticky flags, keeps an interrupt mask, and raises one level interrupt whenever a flagged event is also unmasked. Software reaches it over a plain read/write strobe bus. Reading the status word returns the pending events and also clears them. This lets a driver drop stale events before it launches a new command. The same word carries a live copy of the controller-enabled state, which a status read does not clear.

The mask has no direct write path. One address sets mask bits for every 1 written, a second address clears mask bits for every 1 written, and a third address reads the mask back. A separate output reports command completion, meaning that both the instruction-end event and the chip-select-rise event are pending.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse sets a sticky flag at a fixed status bit. ev_in[0] receive-full maps to bit 0, ev_in[1] transmit-ready to bit 1, ev_in[2] transmitter-idle to bit 2, ev_in[3] overrun to bit 3, ev_in[4] chip-select rise to bit 8, ev_in[5] chip-select fall to bit 9, and ev_in[6] instruction end to bit 10. The flag is set from the clock edge that samples the pulse onward.
- R2: A read of address 0x10 returns the flags on rd_data, with rd_valid high, one cycle after rd_en. The read clears every event flag at that same edge.
- R3: Bit 24 of the status word is the live ctrl_enabled input sampled at the read. A status read never clears it.
- R4: When an event pulse arrives in the same cycle as a status read, its flag is set after the read. The read itself returns the earlier flags.
- R5: A write to address 0x14 sets each mask bit at an event position where the written data has a 1. Zero bits and non-event bit positions leave the mask unchanged.
- R6: A write to address 0x18 clears each mask bit where the written data has a 1. Zero bits leave the mask unchanged.
- R7: A read of address 0x1C returns the mask, with event bits at the positions given in R1. Writes to 0x1C or 0x10 change neither the mask nor the flags.
- R8: irq is registered. It is high in the cycle after any flag AND its mask bit are both 1, and low in the cycle after no such pair exists.
- R9: cmd_done is registered. It is high in the cycle after the instruction-end flag (bit 10) and the chip-select-rise flag (bit 8) are both set.
- R10: A synchronous reset clears all flags, the mask, irq, cmd_done and rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| ev_in | input | 7 | Event pulses from the transfer engine |
| ctrl_enabled | input | 1 | Live controller-enabled state |
| irq | output | 1 | Level interrupt |
| cmd_done | output | 1 | Instruction end and chip-select rise both pending |

## Verification
The hardest case to reach from the ports is an event pulse that lands in exactly the cycle a status read clears the flags. In that case, the returned value and the flags left afterwards must differ. The stimulus drives rd_en and an ev_in bit in the same cycle. The scoreboard expects the pre-read flags from that read and the new flag from the read that follows. Command completion needs two separate pulses with a check in between, so that a design raising cmd_done on only one of the events is caught.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_EV  = 7;
  localparam int EN_BIT  = 24;
  localparam int IX_CSR  = 4;
  localparam int IX_IEND = 6;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_MSET   = 8'h14;
  localparam logic [7:0] OFS_MCLR   = 8'h18;
  localparam logic [7:0] OFS_MASK   = 8'h1C;

  // compact event index to status bit position
  function automatic int ev_pos(input int i);
    return (i < 4) ? i : i + 4;
  endfunction

  function automatic logic [REG_W-1:0] expand(input logic [NUM_EV-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_EV; i++) r[ev_pos(i)] = v[i];
    return r;
  endfunction

  function automatic logic [NUM_EV-1:0] compress(input logic [REG_W-1:0] w);
    logic [NUM_EV-1:0] r;
    for (int i = 0; i < NUM_EV; i++) r[i] = w[ev_pos(i)];
    return r;
  endfunction
endpackage

// File: rtl/status_flags.sv
module status_flags
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic              rd_clr,
  output logic [NUM_EV-1:0] flags_q
);
  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags_q[g] <= 1'b0;
      else if (ev[g])  flags_q[g] <= 1'b1;
      else if (rd_clr) flags_q[g] <= 1'b0;
    end
  end

  // R1
  ev_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((flags_q & $past(ev)) == $past(ev)));
  // R2
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ev == '0) |=> (flags_q == '0));
  // R1
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/mask_reg.sv
module mask_reg
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [REG_W-1:0]  wdata,
  output logic [NUM_EV-1:0] mask_q
);
  logic [NUM_EV-1:0] bits;
  assign bits = compress(wdata);

  for (genvar g = 0; g < NUM_EV; g++) begin : g_mbit
    always_ff @(posedge clk) begin
      if (rst)                    mask_q[g] <= 1'b0;
      else if (set_we && bits[g]) mask_q[g] <= 1'b1;
      else if (clr_we && bits[g]) mask_q[g] <= 1'b0;
    end
  end

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_q & $past(bits)) == $past(bits)));
  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((mask_q & $past(bits)) == '0));
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic [6:0]        ev_in,
  input  logic              ctrl_enabled,
  output logic              irq,
  output logic              cmd_done
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic [NUM_EV-1:0] flags, mask;
  logic              stat_rd;

  assign stat_rd = rd_en && (addr == A_STAT);

  status_flags i_flags (
    .clk(clk), .rst(rst), .ev(ev_in), .rd_clr(stat_rd), .flags_q(flags)
  );

  mask_reg i_mask (
    .clk(clk), .rst(rst),
    .set_we(wr_en && addr == A_MSET),
    .clr_we(wr_en && addr == A_MCLR),
    .wdata(wr_data), .mask_q(mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      cmd_done <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      irq      <= |(flags & mask);
      cmd_done <= flags[IX_IEND] & flags[IX_CSR];
      rd_valid <= rd_en;
      if (rd_en) begin
        if (addr == A_STAT)
          rd_data <= expand(flags) | (REG_W'(ctrl_enabled) << EN_BIT);
        else if (addr == A_MASK)
          rd_data <= expand(mask);
        else
          rd_data <= '0;
      end
    end
  end

  // R8
  no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (mask == '0 && $past(mask) == '0) |-> !irq);
  // R9
  done_needs_iend_chk: assert property (@(posedge clk) disable iff (rst)
    (!flags[IX_IEND]) |=> !cmd_done);
  // R3
  en_bit_live_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data[EN_BIT] == $past(ctrl_enabled)));
  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [6:0]  ev_in = '0;
  logic        ctrl_enabled = 1'b0;
  logic        irq, cmd_done;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ev_in(ev_in), .ctrl_enabled(ctrl_enabled), .irq(irq), .cmd_done(cmd_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (rd_valid && !rst) begin
      if (exp_q.size() == 0) check("R2 unexpected read", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req,
                    input logic [6:0] ev = '0);
    rd_en = 1'b1; addr = a; ev_in = ev;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0; ev_in = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] ev);
    ev_in = ev;
    @(negedge clk);
    ev_in = '0;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 irq", {31'b0, irq}, 32'h0);
    check("R10 cmd_done", {31'b0, cmd_done}, 32'h0);
    rd(8'h10, 32'h0, "R10 status");
    rd(8'h1C, 32'h0, "R10 mask");
    // R3 live enable bit survives reads
    ctrl_enabled = 1'b1;
    rd(8'h10, 32'h0100_0000, "R3 enable bit");
    rd(8'h10, 32'h0100_0000, "R3 enable bit kept");
    // R1 R2 flags set then cleared by read
    pulse(7'b000_1001);
    rd(8'h10, 32'h0100_0009, "R1 flags");
    rd(8'h10, 32'h0100_0000, "R2 cleared");
    // R8 masked flag gives no irq
    pulse(7'b000_0010);
    @(negedge clk);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    // R5 set mask
    wr(8'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    rd(8'h1C, 32'h0000_070F, "R5 mask set");
    // R6 clear one bit
    wr(8'h18, 32'h0000_0002);
    @(negedge clk);
    check("R6 R8 irq off", {31'b0, irq}, 32'h0);
    rd(8'h1C, 32'h0000_070D, "R6 mask clr");
    rd(8'h10, 32'h0100_0002, "R2 pending kept");
    // R4 event during read
    rd(8'h10, 32'h0100_0000, "R4 read value", 7'b010_0000);
    rd(8'h10, 32'h0100_0200, "R4 event kept");
    // R9 command completion needs both flags
    pulse(7'b100_0000);
    @(negedge clk);
    check("R9 one flag", {31'b0, cmd_done}, 32'h0);
    pulse(7'b001_0000);
    @(negedge clk);
    check("R9 both flags", {31'b0, cmd_done}, 32'h1);
    rd(8'h10, 32'h0100_0500, "R9 status");
    @(negedge clk);
    check("R9 done cleared", {31'b0, cmd_done}, 32'h0);
    // R7 writes to mask and status ignored
    wr(8'h1C, 32'h0);
    rd(8'h1C, 32'h0000_070D, "R7 mask write ignored");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0100_0000, "R7 status write ignored");
    ctrl_enabled = 1'b0;
    rd(8'h10, 32'h0, "R3 enable low");
    // R10 reset mid-run
    pulse(7'b000_0001);
    @(negedge clk);
    check("R8 irq before reset", {31'b0, irq}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h10, 32'h0, "R10 flags after reset");
    rd(8'h1C, 32'h0, "R10 mask after reset");
    @(negedge clk);
    check("R2 all reads seen", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule